// File: doc/BRIEF.md
# Random Generator Health Flags

This block holds the health status and interrupt flags of a true random number generator. Two error indications come in asynchronously. One is a clock-condition monitor. The other is a noise-source (seed) error detector. Each passes through its own synchronizer. A level-following status bit and a sticky interrupt bit are then kept for each one.

A clock fault only raises flags. A seed fault halts generation, flushes any buffered output word as untrustworthy, and restarts the initialization sequence when the generator is still initializing. Software clears the sticky bits by writing zero to them. The interrupt request is the OR of the two sticky bits, gated by a global enable.

The generator core uses `gen_halt_o`, `flush_o` and `init_restart_o`. The register layer drives the clear write and reads back the four flag outputs.

Top module: `rng_health_flags`

## Requirements
- R1: After reset, both status bits, both interrupt bits, `irq_o`, `gen_halt_o`, `flush_o` and `init_restart_o` are 0.
- R2: `clk_sts_o` follows `clk_err_i` with a latency of SYNC_STAGES (default 2) clock edges. It returns to 0 by itself once the input is low again.
- R3: `clk_int_o` is set on the edge after a rising edge of the synchronized clock error. It is set only while `clk_sts_o` is 1 and stays 1 after the status clears.
- R4: A clock error never asserts `gen_halt_o`, `flush_o` or `init_restart_o`.
- R5: `seed_sts_o` follows `seed_err_i` with SYNC_STAGES edges of latency. `seed_int_o` is set one edge after the synchronized rise. `gen_halt_o` is 1 exactly while `seed_int_o` is 1.
- R6: Every seed-error rise produces a `flush_o` pulse exactly one cycle long, in the same cycle that `seed_int_o` first reads 1.
- R7: `init_restart_o` pulses together with `flush_o` only if `init_busy_i` is 1 in the cycle the seed event is registered. Otherwise it stays 0.
- R8: A cycle with `wr_en_i`=1 clears an interrupt bit whose `wr_data_i` bit is 0. A 1 in the bit leaves it unchanged. Bit 0 maps to the clock interrupt and bit 1 to the seed interrupt.
- R9: An error event registered in the same cycle as a clearing write leaves the interrupt bit set.
- R10: `irq_o` equals `irq_en_i` AND (`clk_int_o` OR `seed_int_o`), combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_err_i | input | 1 | Asynchronous clock-condition fault level |
| seed_err_i | input | 1 | Asynchronous noise-source fault level |
| init_busy_i | input | 1 | Generator is in its initialization phase |
| irq_en_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Flag register write strobe |
| wr_data_i | input | 2 | Write data; 0 clears, bit0 clock, bit1 seed |
| clk_sts_o | output | 1 | Clock-error current status |
| clk_int_o | output | 1 | Clock-error sticky interrupt bit |
| seed_sts_o | output | 1 | Seed-error current status |
| seed_int_o | output | 1 | Seed-error sticky interrupt bit |
| gen_halt_o | output | 1 | Stop random number generation |
| flush_o | output | 1 | One-cycle pulse invalidating buffered data |
| init_restart_o | output | 1 | One-cycle pulse restarting initialization |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench samples each flag at the exact edge where the synchronizer chain should deliver it. A design with one stage too few or too many shows the status or interrupt a cycle early or late. A clearing write is placed in the very cycle a new clock event registers; a design that lets the clear win loses the interrupt. A write of ones must leave both sticky bits set, and a clock fault must leave halt, flush and restart low. Seed faults are raised both inside and outside initialization, which catches a restart pulse that ignores `init_busy_i`. The interrupt output is also checked with the enable low while a flag is pending.

// File: rtl/rng_health_pkg.sv
package rng_health_pkg;
  parameter int unsigned SYNC_STAGES_DEF = 2;
  parameter int unsigned NUM_SRC = 2;
  // source index also selects the write-data bit
  parameter int unsigned SRC_CLK = 0;
  parameter int unsigned SRC_SEED = 1;
endpackage

// File: rtl/rng_health_sync.sv
module rng_health_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rng_health_flag.sv
module rng_health_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  output logic int_o,
  output logic evt_o
);
  logic prev_q;
  logic int_q;

  assign evt_o = lvl_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      int_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (evt_o) int_q <= 1'b1;       // new event beats clear
      else if (clr_i) int_q <= 1'b0;
    end
  end

  assign int_o = int_q;
endmodule

// File: rtl/rng_health_flags.sv
module rng_health_flags
  import rng_health_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clk_err_i,
  input  logic       seed_err_i,
  input  logic       init_busy_i,
  input  logic       irq_en_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_data_i,
  output logic       clk_sts_o,
  output logic       clk_int_o,
  output logic       seed_sts_o,
  output logic       seed_int_o,
  output logic       gen_halt_o,
  output logic       flush_o,
  output logic       init_restart_o,
  output logic       irq_o
);
  logic [NUM_SRC-1:0] raw_err, lvl, ints, evts, clrs;

  assign raw_err[SRC_CLK]  = clk_err_i;
  assign raw_err[SRC_SEED] = seed_err_i;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      rng_health_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw_err[g]),
        .q_o   (lvl[g])
      );
      assign clrs[g] = wr_en_i & ~wr_data_i[g];
      rng_health_flag i_flag (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (lvl[g]),
        .clr_i (clrs[g]),
        .int_o (ints[g]),
        .evt_o (evts[g])
      );
    end
  endgenerate

  logic flush_q, restart_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q   <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      flush_q   <= evts[SRC_SEED];
      restart_q <= evts[SRC_SEED] & init_busy_i;
    end
  end

  assign clk_sts_o      = lvl[SRC_CLK];
  assign clk_int_o      = ints[SRC_CLK];
  assign seed_sts_o     = lvl[SRC_SEED];
  assign seed_int_o     = ints[SRC_SEED];
  assign gen_halt_o     = ints[SRC_SEED];
  assign flush_o        = flush_q;
  assign init_restart_o = restart_q;
  assign irq_o          = irq_en_i & (|ints);
endmodule

// File: rtl/rng_health_flags_chk.sv
module rng_health_flags_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] wr_data_i,
  input logic       clk_sts_o,
  input logic       clk_int_o,
  input logic       seed_int_o,
  input logic       gen_halt_o,
  input logic       flush_o,
  input logic       init_restart_o,
  input logic       irq_o
);
  // R3
  clk_int_needs_sts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_int_o) |-> clk_sts_o);
  // R4
  halt_only_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gen_halt_o) |-> flush_o);
  // R6
  flush_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
  // R7
  restart_with_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_restart_o |-> flush_o);
  // R8
  write_one_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[0] && clk_int_o) |=> clk_int_o);
  // R10
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (clk_int_o || seed_int_o));
endmodule

bind rng_health_flags rng_health_flags_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .clk_sts_o     (clk_sts_o),
  .clk_int_o     (clk_int_o),
  .seed_int_o    (seed_int_o),
  .gen_halt_o    (gen_halt_o),
  .flush_o       (flush_o),
  .init_restart_o(init_restart_o),
  .irq_o         (irq_o)
);

// File: tb/test_rng_health_flags.sv
module test_rng_health_flags;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_err = 0, seed_err = 0, init_busy = 0, irq_en = 0, wr_en = 0;
  logic [1:0] wr_data = 2'b11;
  logic clk_sts, clk_int, seed_sts, seed_int, halt, flush, restart, irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rng_health_flags i_rng_health_flags (
    .clk_i(clk), .rst_ni(rst_n), .clk_err_i(clk_err), .seed_err_i(seed_err),
    .init_busy_i(init_busy), .irq_en_i(irq_en), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .clk_sts_o(clk_sts), .clk_int_o(clk_int), .seed_sts_o(seed_sts),
    .seed_int_o(seed_int), .gen_halt_o(halt), .flush_o(flush),
    .init_restart_o(restart), .irq_o(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [1:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0; wr_data = 2'b11;
  endtask

  task automatic t_reset();
    chk("R1 clk_sts", clk_sts, 0); chk("R1 clk_int", clk_int, 0);
    chk("R1 seed_sts", seed_sts, 0); chk("R1 seed_int", seed_int, 0);
    chk("R1 halt", halt, 0); chk("R1 flush", flush, 0);
    chk("R1 restart", restart, 0); chk("R1 irq", irq, 0);
  endtask

  task automatic t_clock_fault();
    irq_en = 1; clk_err = 1;
    step(); chk("R2 sts after 1 edge", clk_sts, 0);
    step(); chk("R2 sts after 2 edges", clk_sts, 1); chk("R3 int not yet", clk_int, 0);
    step(); chk("R3 int set", clk_int, 1); chk("R10 irq", irq, 1);
    chk("R4 no halt", halt, 0); chk("R4 no flush", flush, 0); chk("R4 no restart", restart, 0);
    clk_err = 0; step(); step();
    chk("R2 sts self clear", clk_sts, 0); chk("R3 int sticky", clk_int, 1);
    wr(2'b11); chk("R8 write one keeps", clk_int, 1);
    irq_en = 0; #1 chk("R10 irq gated", irq, 0); irq_en = 1;
    wr(2'b10); chk("R8 write zero clears", clk_int, 0); chk("R10 irq low", irq, 0);
  endtask

  task automatic t_collision();
    clk_err = 1; step(); step();
    wr_en = 1; wr_data = 2'b00; step(); wr_en = 0; wr_data = 2'b11;
    chk("R9 event beats clear", clk_int, 1);
    clk_err = 0; step(); step(); wr(2'b10); chk("R8 cleared after", clk_int, 0);
  endtask

  task automatic t_seed(input logic busy);
    init_busy = busy; seed_err = 1;
    step(); chk("R5 seed_sts early", seed_sts, 0);
    step(); chk("R5 seed_sts set", seed_sts, 1); chk("R5 halt not yet", halt, 0);
    step(); chk("R5 seed_int set", seed_int, 1); chk("R5 halt", halt, 1);
    chk("R6 flush pulse", flush, 1); chk("R7 restart", restart, busy);
    step(); chk("R6 flush ends", flush, 0); chk("R7 restart ends", restart, 0);
    seed_err = 0; init_busy = 0; step(); step();
    chk("R5 seed_sts clear", seed_sts, 0); chk("R5 halt held", halt, 1);
    wr(2'b01); chk("R8 seed clear", seed_int, 0); chk("R5 halt released", halt, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset();
    t_clock_fault();
    t_collision();
    t_seed(1'b1);
    t_seed(1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule